// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block works out where a 32-bit integer core goes next. It takes the current program counter, the raw instruction word and the two source register values. For the six conditional branches, the direct jump and the register jump, it produces the next PC, a taken flag, a return-address (link) value and a link-write enable. The branch and jump offsets sit in scattered bit fields of the instruction word. The block puts them back together itself and sign-extends them from instruction bit 31.

The decision logic is purely combinational. So that the block can be exercised one instruction per cycle, a PC register is included. It loads a start address on a synchronous active-high reset. After that it follows the computed next PC on every clock edge where the step input is high. Any instruction that is not a control transfer advances the PC by 4 and requests no link write.

Top module: `npc_unit`

## Requirements
- R1: Opcode 1100011 (binary) is a conditional branch. funct3 (instruction bits 14:12) selects the condition applied to rs1 against rs2: 000 equal, 001 not equal, 100 signed less than, 101 signed greater-or-equal, 110 unsigned less than, 111 unsigned greater-or-equal. funct3 values 010 and 011 are never taken.
- R2: A taken branch gives next_pc = pc + branch offset. A branch that is not taken gives next_pc = pc + 4. taken is high exactly when a branch condition holds, or when a jump is decoded.
- R3: The branch offset is {sign from bit 31 ×19, bit 31, bit 7, bits 30:25, bits 11:8, 0}. Its bit 0 is always zero.
- R4: Opcode 1101111 is the direct jump. next_pc = pc + jump offset, where the jump offset is {sign ×11, bit 31, bits 19:12, bit 20, bits 30:21, 0}.
- R5: Opcode 1100111 is the register jump. next_pc = (rs1 + sign-extended bits 31:20) with bit 0 cleared.
- R6: Both jumps give link_val = pc + 4. link_we is high for either jump unless rd (bits 11:7) is zero. Branches and all other opcodes never assert link_we.
- R7: Any other opcode gives next_pc = pc + 4 and taken = 0.
- R8: A synchronous active-high reset loads pc with parameter START_PC. When step is high, pc takes next_pc at the clock edge. When step is low, pc holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance the PC register to next_pc |
| instr | input | 32 | Instruction word for the current PC |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| pc | output | 32 | Current program counter (registered) |
| next_pc | output | 32 | Computed next program counter |
| taken | output | 1 | Control transfer redirects the PC |
| link_val | output | 32 | Return address pc+4 |
| link_we | output | 1 | Write link_val to rd |

## Verification
Two functions can fall in the same cycle. A jump redirects the PC and also writes a link value. The register jump additionally clears bit 0 of a target computed from rs1, while the link is computed from pc. The bench provokes this with random jumps whose rs1 and immediate give odd sums and whose rd is sometimes zero. In that same cycle it compares next_pc, taken, link_val and link_we against its own model. The registered pc is then checked again one edge later, to confirm it followed the redirect.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int XLEN = 32;

    typedef enum logic [6:0] {
        OPC_BRANCH = 7'b1100011,
        OPC_JDIR   = 7'b1101111,
        OPC_JREG   = 7'b1100111
    } opc_e;

    typedef enum logic [1:0] {
        CT_NONE, CT_BRANCH, CT_JDIR, CT_JREG
    } ct_kind_e;

    typedef struct packed {
        ct_kind_e    kind;
        logic [2:0]  cond;
        logic [4:0]  rd;
        logic [XLEN-1:0] imm;
    } ct_dec_t;

    function automatic logic [XLEN-1:0] branch_imm(input logic [31:0] w);
        return {{(XLEN-12){w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic logic [XLEN-1:0] jump_imm(input logic [31:0] w);
        return {{(XLEN-20){w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
    endfunction

    function automatic logic [XLEN-1:0] itype_imm(input logic [31:0] w);
        return {{(XLEN-12){w[31]}}, w[31:20]};
    endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [31:0] instr,
    output ct_dec_t     dec
);
    always_comb begin
        dec.cond = instr[14:12];
        dec.rd   = instr[11:7];
        unique case (instr[6:0])
            OPC_BRANCH: begin dec.kind = CT_BRANCH; dec.imm = branch_imm(instr); end
            OPC_JDIR:   begin dec.kind = CT_JDIR;   dec.imm = jump_imm(instr);   end
            OPC_JREG:   begin dec.kind = CT_JREG;   dec.imm = itype_imm(instr);  end
            default:    begin dec.kind = CT_NONE;   dec.imm = '0;                end
        endcase
    end

    // R3
    always_comb begin
        branch_lsb_chk: assert (dec.kind != CT_BRANCH || dec.imm[0] == 1'b0);
    end
endmodule

// File: rtl/npc_compare.sv
module npc_compare
    import npc_pkg::*;
(
    input  logic [2:0]      cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hold
);
    logic eq, lts, ltu;
    assign eq  = (a == b);
    assign lts = ($signed(a) < $signed(b));
    assign ltu = (a < b);

    always_comb begin
        unique case (cond)
            3'b000:  hold = eq;
            3'b001:  hold = !eq;
            3'b100:  hold = lts;
            3'b101:  hold = !lts;
            3'b110:  hold = ltu;
            3'b111:  hold = !ltu;
            default: hold = 1'b0;
        endcase
    end

    // R1
    always_comb begin
        cond_pair_chk: assert (!(cond == 3'b000 && hold) || a == b);
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  ct_dec_t         dec,
    input  logic            cmp_hold,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    output logic [XLEN-1:0] next_pc,
    output logic            taken,
    output logic [XLEN-1:0] link_val,
    output logic            link_we
);
    logic [XLEN-1:0] seq_pc, rel_pc, reg_sum;
    assign seq_pc  = pc + XLEN'(4);
    assign rel_pc  = pc + dec.imm;
    assign reg_sum = rs1 + dec.imm;

    always_comb begin
        taken   = 1'b0;
        next_pc = seq_pc;
        link_we = 1'b0;
        unique case (dec.kind)
            CT_BRANCH: begin
                taken = cmp_hold;
                if (cmp_hold) next_pc = rel_pc;
            end
            CT_JDIR: begin
                taken   = 1'b1;
                next_pc = rel_pc;
                link_we = (dec.rd != 5'd0);
            end
            CT_JREG: begin
                taken   = 1'b1;
                next_pc = {reg_sum[XLEN-1:1], 1'b0};
                link_we = (dec.rd != 5'd0);
            end
            default: ;
        endcase
    end
    assign link_val = seq_pc;

    // R5
    always_comb begin
        jreg_even_chk: assert (dec.kind != CT_JREG || next_pc[0] == 1'b0);
    end
    // R6
    always_comb begin
        link_zero_chk: assert (!(link_we && dec.rd == 5'd0));
    end
    // R2
    always_comb begin
        seq_step_chk: assert (taken || next_pc == pc + XLEN'(4));
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] START_PC = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic [31:0] instr,
    input  logic [31:0] rs1_val,
    input  logic [31:0] rs2_val,
    output logic [31:0] pc,
    output logic [31:0] next_pc,
    output logic        taken,
    output logic [31:0] link_val,
    output logic        link_we
);
    ct_dec_t dec;
    logic    hold;

    npc_decode u_dec (.instr(instr), .dec(dec));
    npc_compare u_cmp (.cond(dec.cond), .a(rs1_val), .b(rs2_val), .hold(hold));
    npc_target u_tgt (
        .dec(dec), .cmp_hold(hold), .pc(pc), .rs1(rs1_val),
        .next_pc(next_pc), .taken(taken), .link_val(link_val), .link_we(link_we)
    );

    always_ff @(posedge clk) begin
        if (rst)       pc <= START_PC;
        else if (step) pc <= next_pc;
    end

    // R8
    pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> pc == $past(next_pc));
    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [31:0] instr = 32'h0000_0013;
    logic [31:0] rs1_val = '0, rs2_val = '0;
    logic [31:0] pc, next_pc, link_val;
    logic        taken, link_we;
    int checks = 0, errors = 0;
    logic [31:0] mpc;

    always #4 clk = ~clk;

    npc_unit i_npc_unit (.clk(clk), .rst(rst), .step(step), .instr(instr),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc), .next_pc(next_pc),
        .taken(taken), .link_val(link_val), .link_we(link_we));

    function automatic logic [32:0] model_take(input logic [31:0] w, input logic [31:0] a,
                                               input logic [31:0] b, input logic [31:0] p);
        logic t; logic [31:0] off, n;
        off = '0; t = 1'b0;
        case (w[6:0])
            7'b1100011: begin
                case (w[14:12])
                    3'd0: t = (a == b);
                    3'd1: t = (a != b);
                    3'd4: t = ($signed(a) < $signed(b));
                    3'd5: t = ($signed(a) >= $signed(b));
                    3'd6: t = (a < b);
                    3'd7: t = (a >= b);
                    default: t = 1'b0;
                endcase
                off = {{20{w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
                n = t ? p + off : p + 4;
            end
            7'b1101111: begin
                t = 1'b1;
                off = {{12{w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
                n = p + off;
            end
            7'b1100111: begin
                t = 1'b1;
                n = (a + {{20{w[31]}}, w[31:20]}) & ~32'd1;
            end
            default: n = p + 4;
        endcase
        return {t, n};
    endfunction

    function automatic logic model_we(input logic [31:0] w);
        return (w[6:0] == 7'b1101111 || w[6:0] == 7'b1100111) && w[11:7] != 5'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b);
        logic [32:0] m;
        instr = w; rs1_val = a; rs2_val = b; step = 1'b1;
        #2;
        m = model_take(w, a, b, mpc);
        chk(req, {31'd0, taken}, {31'd0, m[32]});
        chk(req, next_pc, m[31:0]);
        chk("R6", {31'd0, link_we}, {31'd0, model_we(w)});
        if (model_we(w)) chk("R6", link_val, mpc + 4);
        @(posedge clk); #2;
        mpc = m[31:0];
        chk("R8", pc, mpc);
    endtask

    function automatic logic [31:0] mk_br(input logic [12:0] off, input logic [2:0] f);
        return {off[12], off[10:5], 5'd2, 5'd1, f, off[4:1], off[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] mk_jal(input logic [20:0] off, input logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        mpc = 32'h0000_1000;
        chk("R8", pc, 32'h0000_1000);
        // R1 directed conditions, signed/unsigned divergence
        apply("R1", mk_br(13'h010, 3'd0), 32'd5, 32'd5);
        apply("R1", mk_br(13'h010, 3'd1), 32'd5, 32'd5);
        apply("R1", mk_br(13'h020, 3'd4), 32'hFFFF_FFFF, 32'd1);
        apply("R1", mk_br(13'h020, 3'd6), 32'hFFFF_FFFF, 32'd1);
        apply("R1", mk_br(13'h020, 3'd5), 32'h8000_0000, 32'h7FFF_FFFF);
        apply("R1", mk_br(13'h020, 3'd7), 32'h8000_0000, 32'h7FFF_FFFF);
        apply("R1", mk_br(13'h020, 3'd2), 32'd1, 32'd1);
        // R3 negative and extreme offsets
        apply("R3", mk_br(13'h1FFE, 3'd0), 32'd0, 32'd0);
        apply("R3", mk_br(13'h1000, 3'd0), 32'd0, 32'd0);
        apply("R3", mk_br(13'h0FFE, 3'd0), 32'd0, 32'd0);
        // R4 jump offsets
        apply("R4", mk_jal(21'h100000, 5'd1), 0, 0);
        apply("R4", mk_jal(21'h0FFFFE, 5'd0), 0, 0);
        apply("R4", mk_jal(21'h000802, 5'd3), 0, 0);
        // R5 odd sum cleared
        apply("R5", {12'h003, 5'd1, 3'd0, 5'd1, 7'b1100111}, 32'h0000_2000, 0);
        apply("R5", {12'hFFF, 5'd1, 3'd0, 5'd0, 7'b1100111}, 32'h0000_0000, 0);
        // R7 non-transfer
        apply("R7", 32'h0000_0013, 0, 0);
        // R8 hold
        step = 1'b0; instr = mk_jal(21'h000100, 5'd1);
        @(posedge clk); #2;
        chk("R8", pc, mpc);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w, a, b;
            w = $urandom;
            case ($urandom_range(3))
                0: w[6:0] = 7'b1100011;
                1: w[6:0] = 7'b1101111;
                2: w[6:0] = 7'b1100111;
                default: ;
            endcase
            a = $urandom; b = ($urandom_range(3) == 0) ? a : $urandom;
            apply("R2", w, a, b);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule